// File: doc/BRIEF.md
# Backlight PWM Generator with Committed Configuration

This block drives a single pulse-width-modulated line for display backlight dimming. Software programs three counts through a small word-addressed register interface: a clock prescaler, a period length and a high-time length. Every count uses a plus-one encoding, so a field value of zero means one unit.

New values are written into staging registers first and have no effect on the running waveform. A commit is triggered by a 0-to-1 transition of a dedicated commit bit. It captures all three staged counts together. The captured set becomes active at the next period boundary, so a period in progress always finishes on the settings it started with, and no period ever mixes old and new fields.

A separate enable bit gates the whole generator. While it is clear, the line is low and the counters are parked at zero. Setting it starts a fresh period.

Top module: `bklt_pwm`

## Requirements
- R1: After reset, every mapped register reads zero and `pwmOut` is low.
- R2: Byte offsets 0x00 (enable, bit 0), 0x08 (commit, bit 0), 0x10 (word of 32 stored bits, prescaler in [25:16]) and 0x14 (period in [11:0], high width in [28:16], other bits read 0) read back their staged contents. Any other offset reads zero, and writes to it change nothing.
- R3: When enable bit 0 is 0, `pwmOut` is low from the cycle after that write and stays low.
- R4: With prescaler D and period P active, one output period lasts (D+1)*(P+1) clock cycles.
- R5: With high width H < P, the output is high for the first (D+1)*(H+1) cycles of each period and low for the rest.
- R6: With H >= P, the output stays high for as long as the block is enabled.
- R7: Writes to the staging registers alone leave the running waveform unchanged.
- R8: A commit happens only when a write changes the commit bit from 0 to 1. Writing 1 while it already holds 1 commits nothing.
- R9: Committed values take effect at the next period boundary. The period during which the commit occurs completes with the old settings.
- R10: Setting enable starts a new period at count zero, so `pwmOut` is high in the first cycle after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W (8) | Byte offset of the accessed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pwmOut | output | 1 | Modulated backlight drive |

## Verification
A corrupt prescaler or period count distorts the very next period's high or low run length, so measuring one full period per setting exposes it within (D+1)*(P+1) cycles. A lost or spurious commit appears as the previous waveform persisting, or a new one arriving, one boundary late or early. This becomes visible at the first rising edge after the commit. Faults in the pending-to-active transfer show up as a period of the wrong length straddling a mid-period commit, so the bench measures the low run of that exact period. Stuck or mismatched staging bits appear immediately on readback at the register's offset.

// File: rtl/bklt_pwm_pkg.sv
package bklt_pwm_pkg;
  // field widths of the three counts
  localparam int DIV_W  = 10;
  localparam int PER_W  = 12;
  localparam int HI_W   = 13;
  localparam int DATA_W = 32;

  // field positions inside their words (software decodes these)
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = 16;

  // byte offsets of the register words
  localparam int OFF_EN   = 'h00;
  localparam int OFF_CMT  = 'h08;
  localparam int OFF_CTL0 = 'h10;
  localparam int OFF_CTL1 = 'h14;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [HI_W-1:0]  hi;
  } pwmCfg_t;

  typedef struct packed {
    logic enable;
    logic commitPulse;
  } ctrlStrb_t;
endpackage

// File: rtl/bklt_pwm_regs.sv
module bklt_pwm_regs
  import bklt_pwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output ctrlStrb_t         strb,
  output pwmCfg_t           staged
);
  logic              enBit;
  logic              cmtBit;
  logic [DATA_W-1:0] ctl0Word;
  logic [PER_W-1:0]  perStg;
  logic [HI_W-1:0]   hiStg;

  logic hitEn, hitCmt, hitCtl0, hitCtl1;

  assign hitEn   = (busAddr == ADDR_W'(OFF_EN));
  assign hitCmt  = (busAddr == ADDR_W'(OFF_CMT));
  assign hitCtl0 = (busAddr == ADDR_W'(OFF_CTL0));
  assign hitCtl1 = (busAddr == ADDR_W'(OFF_CTL1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      cmtBit   <= 1'b0;
      ctl0Word <= '0;
      perStg   <= '0;
      hiStg    <= '0;
    end else if (busWe) begin
      if (hitEn)   enBit    <= busWdata[0];
      if (hitCmt)  cmtBit   <= busWdata[0];
      if (hitCtl0) ctl0Word <= busWdata;
      if (hitCtl1) begin
        perStg <= busWdata[PER_LSB +: PER_W];
        hiStg  <= busWdata[HI_LSB +: HI_W];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitEn)   busRdata[0] = enBit;
    if (hitCmt)  busRdata[0] = cmtBit;
    if (hitCtl0) busRdata    = ctl0Word;
    if (hitCtl1) begin
      busRdata[PER_LSB +: PER_W] = perStg;
      busRdata[HI_LSB +: HI_W]   = hiStg;
    end
  end

  // commit fires only on a written 0 -> 1 change of the commit bit
  assign strb.enable      = enBit;
  assign strb.commitPulse = busWe && hitCmt && busWdata[0] && !cmtBit;

  assign staged.div = ctl0Word[DIV_LSB +: DIV_W];
  assign staged.per = perStg;
  assign staged.hi  = hiStg;
endmodule

// File: rtl/bklt_pwm_core.sv
module bklt_pwm_core
  import bklt_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  pwmCfg_t   staged,
  output logic      pwmOut
);
  pwmCfg_t          pendCfg;
  pwmCfg_t          actCfg;
  logic             pendValid;
  logic [DIV_W-1:0] preCnt;
  logic [PER_W-1:0] perCnt;
  logic             tick;
  logic             wrap;
  logic             loadAct;

  assign tick    = (preCnt == actCfg.div);
  assign wrap    = tick && (perCnt == actCfg.per);
  // pending set moves in while parked or exactly at a period boundary
  assign loadAct = pendValid && (!strb.enable || wrap);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!strb.enable) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      perCnt <= wrap ? '0 : perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg   <= '0;
      actCfg    <= '0;
      pendValid <= 1'b0;
    end else begin
      if (loadAct) begin
        actCfg    <= pendCfg;
        pendValid <= 1'b0;
      end
      if (strb.commitPulse) begin
        pendCfg   <= staged;
        pendValid <= 1'b1;
      end
    end
  end

  // high while the period count has not passed the high width;
  // a width at or above the period therefore keeps the line high
  assign pwmOut = strb.enable && ({1'b0, perCnt} <= actCfg.hi);
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
  import bklt_pwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              pwmOut
);
  ctrlStrb_t strb;
  pwmCfg_t   staged;

  bklt_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .strb     (strb),
    .staged   (staged)
  );

  bklt_pwm_core u_core (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .staged (staged),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk
  import bklt_pwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wdBit0,
  input logic [31:0]       busRdata,
  input logic              pwmOut,
  input ctrlStrb_t         strb,
  input pwmCfg_t           staged
);
  logic wrEn0;
  logic isMapped;
  assign wrEn0 = busWe && (busAddr == ADDR_W'(OFF_EN)) && !wdBit0;
  assign isMapped = (busAddr == ADDR_W'(OFF_EN))   || (busAddr == ADDR_W'(OFF_CMT)) ||
                    (busAddr == ADDR_W'(OFF_CTL0)) || (busAddr == ADDR_W'(OFF_CTL1));

  // R3: clearing enable forces the line low next cycle
  p_off_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn0 |=> !pwmOut);

  // R10: the first enabled cycle is the start of a period, so high
  p_fresh_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.enable) |-> pwmOut);

  // R8: a commit needs a write of 1 while the commit bit reads 0
  p_commit_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitPulse |-> (busWe && busAddr == ADDR_W'(OFF_CMT) && wdBit0 && !busRdata[0]));

  // R7: staged counts move only with a write
  p_staged_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(staged));

  // R2: reserved bits of the period/width word read zero
  p_ctl1_resv_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_CTL1)) |-> (busRdata[15:12] == 4'd0 && busRdata[31:29] == 3'd0));

  // R2: unmapped offsets read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> (busRdata == 32'd0));
endmodule

bind bklt_pwm bklt_pwm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .wdBit0   (busWdata[0]),
  .busRdata (busRdata),
  .pwmOut   (pwmOut),
  .strb     (strb),
  .staged   (staged)
);

// File: tb/bklt_pwm_bench.sv
module bklt_pwm_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        pwmOut;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  bklt_pwm u_bklt_pwm (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // {div, per, hi, expected high cycles, expected period cycles}
  localparam int VEC [5][5] = '{
    '{0, 9, 3,  4, 10},
    '{2, 4, 1,  6, 15},
    '{1, 7, 0,  2, 16},
    '{3, 5, 4, 20, 24},
    '{0, 2, 1,  2,  3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a[7:0]; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = 32'd0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    busAddr = a[7:0];
    #1 d = busRdata;
  endtask

  task automatic countPeriod(output int hiCnt, output int loCnt);
    hiCnt = 0; loCnt = 0;
    while (pwmOut && hiCnt < 5000) begin hiCnt++; @(negedge clk); end
    while (!pwmOut && loCnt < 5000) begin loCnt++; @(negedge clk); end
  endtask

  task automatic syncRise();
    int n = 0;
    while (pwmOut && n < 5000) begin n++; @(negedge clk); end
    while (!pwmOut && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic setupDisabled(input int dv, input int pr, input int hw);
    wr('h00, 32'd0);
    wr('h10, 32'(dv) << 16);
    wr('h14, (32'(hw) << 16) | 32'(pr));
    wr('h08, 32'd1);
    wr('h08, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, l, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd('h00, d); chk("R1 enable", int'(d), 0);
    rd('h08, d); chk("R1 commit", int'(d), 0);
    rd('h10, d); chk("R1 ctl0", int'(d), 0);
    rd('h14, d); chk("R1 ctl1", int'(d), 0);
    chk("R1 pwmOut", int'(pwmOut), 0);

    // R2 readback masks and unmapped offsets
    wr('h10, 32'hFFFF_FFFF); rd('h10, d); chk("R2 ctl0 all bits", int'(d), int'(32'hFFFF_FFFF));
    wr('h14, 32'hFFFF_FFFF); rd('h14, d); chk("R2 ctl1 fields", int'(d), int'(32'h1FFF_0FFF));
    wr('h0C, 32'hFFFF_FFFF); rd('h0C, d); chk("R2 unmapped read", int'(d), 0);
    rd('h00, d); chk("R2 enable after unmapped write", int'(d), 0);
    rd('h08, d); chk("R2 commit after unmapped write", int'(d), 0);
    chk("R2 pwmOut after unmapped write", int'(pwmOut), 0);
    wr('h00, 32'hFFFF_FFFE); rd('h00, d); chk("R2 enable bit only", int'(d), 0);

    // R4 R5 R10: vector table, first period after enabling
    for (int i = 0; i < 5; i++) begin
      setupDisabled(VEC[i][0], VEC[i][1], VEC[i][2]);
      wr('h00, 32'd1);
      chk("R10 high right after enable", int'(pwmOut), 1);
      countPeriod(h, l);
      chk("R5 high cycles", h, VEC[i][3]);
      chk("R4 period cycles", h + l, VEC[i][4]);
    end

    // R3: disabling keeps the line low
    wr('h00, 32'd0);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin cnt += int'(pwmOut); @(negedge clk); end
    chk("R3 low while disabled", cnt, 0);

    // R8: writing 1 over 1 is not a commit
    wr('h10, 32'd0);
    wr('h14, (32'd3 << 16) | 32'd9);
    wr('h08, 32'd1);
    wr('h00, 32'd1);
    countPeriod(h, l);
    chk("R8 base high", h, 4);
    wr('h14, (32'd1 << 16) | 32'd5);
    wr('h08, 32'd1);
    syncRise(); syncRise(); countPeriod(h, l);
    chk("R8 no re-commit high", h, 4);
    chk("R8 no re-commit period", h + l, 10);
    wr('h08, 32'd0);
    wr('h08, 32'd1);
    syncRise(); syncRise(); countPeriod(h, l);
    chk("R8 commit after 0 high", h, 2);
    chk("R8 commit after 0 period", h + l, 6);

    // R7: staging alone leaves the waveform unchanged
    wr('h08, 32'd0);
    wr('h14, (32'd3 << 16) | 32'd9);
    rd('h14, d); chk("R7 staged readback", int'(d), int'(32'h0003_0009));
    syncRise(); syncRise(); countPeriod(h, l);
    chk("R7 high unchanged", h, 2);
    chk("R7 period unchanged", h + l, 6);

    // R9: commit mid-period, old period completes
    setupDisabled(0, 9, 3);
    wr('h00, 32'd1);
    wr('h14, (32'd9 << 16) | 32'd19);
    wr('h08, 32'd1);
    wr('h08, 32'd0);
    h = 0;
    while (pwmOut && h < 100) begin h++; @(negedge clk); end
    l = 0;
    while (!pwmOut && l < 100) begin l++; @(negedge clk); end
    chk("R9 old low run kept", l, 6);
    countPeriod(h, l);
    chk("R9 new high", h, 10);
    chk("R9 new period", h + l, 20);

    // R6: width at or above period holds the line high
    for (int j = 0; j < 3; j++) begin
      int dv = (j == 1) ? 1 : 0;
      int pr = (j == 0) ? 4 : ((j == 1) ? 2 : 0);
      int hw = (j == 0) ? 4 : ((j == 1) ? 7 : 0);
      setupDisabled(dv, pr, hw);
      wr('h00, 32'd1);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin cnt += int'(!pwmOut); @(negedge clk); end
      chk("R6 low cycles with wide high", cnt, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule